// File: doc/BRIEF.md
# Word-Serial Modular Adder-Subtractor

The block computes a modular difference (x − y) mod m or a modular sum (x + y) mod m. Each operand has E words of W bits. The datapath handles one word per clock cycle, starting at the least significant word. Two W-bit ripple adder rows are chained. Each row keeps its own carry flop from one word to the next. The first row combines x with y, or with the bitwise complement of y. The second row adds a word that depends on the modulus. Each pass also has one extra cycle for a sign word above the most significant operand word. The sign word of the first pass decides whether a second pass over all words is needed.

In a subtraction the first pass computes x − y. The carry into the first row is 1 and the second row adds zero. If the difference is negative, a correction pass adds m to the stored difference. In an addition the first pass computes x + y and, in the same cycles, x + y − m. If the trial result is negative, a correction pass copies the plain sum, which was kept in a temporary store, into the result. The caller drives the operand buses, pulses start, and reads the result bus once done goes high.

The control has four states, each with a name:
- `ST_IDLE` waits for start.
- `ST_SUM` is the first pass.
- `ST_FIX` is the correction pass.
- `ST_DONE` is a one-cycle completion state.

The transitions are as follows:
- *accept*: `ST_IDLE`→`ST_SUM` on start.
- *word step*: `ST_SUM`→`ST_SUM` and `ST_FIX`→`ST_FIX` while the word index is below E.
- *sign negative*: `ST_SUM`→`ST_FIX` on the last cycle when the sign word's top bit is set.
- *sign clear*: `ST_SUM`→`ST_DONE` on the last cycle otherwise.
- *fix end*: `ST_FIX`→`ST_DONE` on its last cycle.
- *release*: `ST_DONE`→`ST_IDLE`.

Top module: `wsmas_top`

## Requirements
- R1: While reset is active, and just after it, busy_o and done_o are 0 and s_o is all zeros.
- R2: With op_i = 1 (subtract), s_o equals (x + m − y) mod m for any x, y < m.
- R3: With op_i = 0 (add), s_o equals (x + y) mod m for any x, y < m.
- R4: A subtraction keeps busy_o high for E+1 cycles when x ≥ y and for 2(E+1) cycles when x < y. done_o follows in the next cycle. Counting clock edges from the accepting edge, done_o is first high after E+2 or 2E+3 edges.
- R5: An addition keeps busy_o high for E+1 cycles when x + y ≥ m and for 2(E+1) cycles when x + y < m. done_o follows in the next cycle.
- R6: done_o is high for exactly one cycle per operation, never at the same time as busy_o, and busy_o and done_o are both low in the cycle after done_o.
- R7: A start pulse, or a change of op_i, while busy_o is high has no effect on that operation's result or its latency.
- R8: s_o changes only while busy_o is high. Between operations it holds the last result even when the operand inputs change.
- R9: Boundary cases give exact results. Subtracting x − x gives 0 with no correction. Subtracting with y = 0 gives x. Subtracting 0 − (m−1) gives 1. Adding (m−1) + 1 gives 0 when m > 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when the block is idle |
| op_i | input | 1 | 1 = subtract, 0 = add; sampled with start_i |
| x_i | input | E*W | Operand x, word k at bits [k*W +: W] |
| y_i | input | E*W | Operand y, same word layout |
| m_i | input | E*W | Modulus m, same word layout |
| busy_o | output | 1 | High during the first pass and the correction pass |
| done_o | output | 1 | One-cycle completion pulse |
| s_o | output | E*W | Result, same word layout |

## Verification
The checks assume the following about the inputs:
- x_i, y_i and m_i stay constant from the accepting edge until done_o.
- m is nonzero.
- Both x and y are below m.
- W is at least 2, so the sign word's top bit is a true sign.
- start_i is raised only while the block is idle.

The one exception to the last point is deliberate: the stimulus pokes start_i and op_i during busy to exercise R7. Otherwise the stimulus drives operands only from value loops bounded by each modulus, and changes them only after done_o has been seen. The bound on the busy run in the checker holds only while the operand inputs are held.

// File: rtl/wsmas_pkg.sv
package wsmas_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SUM  = 2'd1,
        ST_FIX  = 2'd2,
        ST_DONE = 2'd3
    } wsmas_state_e;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } wsmas_op_e;

endpackage

// File: rtl/wsmas_word_adder.sv
module wsmas_word_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    logic [W:0] carry;

    assign carry[0] = cin_i;

    for (genvar g = 0; g < W; g++) begin : g_fa
        assign sum_o[g]     = a_i[g] ^ b_i[g] ^ carry[g];
        assign carry[g + 1] = (a_i[g] & b_i[g]) | (carry[g] & (a_i[g] ^ b_i[g]));
    end

    assign cout_o = carry[W];

endmodule

// File: rtl/wsmas_ctrl.sv
module wsmas_ctrl
    import wsmas_pkg::*;
#(
    parameter int E  = 4,
    parameter int IW = $clog2(E + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          op_i,
    input  logic          need_fix_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          fix_o,
    output logic          sub_o,
    output logic          first_o,
    output logic [IW-1:0] idx_o
);

    wsmas_state_e state_q, state_d;
    wsmas_op_e    op_q;
    logic [IW-1:0] idx_q;
    logic          last_word;
    logic          in_pass;

    assign last_word = (idx_q == IW'(E));
    assign in_pass   = (state_q == ST_SUM) || (state_q == ST_FIX);

    // State register, word index and latched operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            op_q    <= OP_ADD;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                op_q <= wsmas_op_e'(op_i);
            end
            if (in_pass) begin
                idx_q <= last_word ? '0 : idx_q + IW'(1);
            end
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_SUM;
            ST_SUM:  if (last_word) state_d = need_fix_i ? ST_FIX : ST_DONE;
            ST_FIX:  if (last_word) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy_o  = 1'b0;
        done_o  = 1'b0;
        fix_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SUM:  busy_o = 1'b1;
            ST_FIX:  begin busy_o = 1'b1; fix_o = 1'b1; end
            ST_DONE: done_o = 1'b1;
        endcase
        sub_o   = (op_q == OP_SUB);
        first_o = (idx_q == '0);
        idx_o   = idx_q;
    end

endmodule

// File: rtl/wsmas_top.sv
module wsmas_top #(
    parameter int W = 8,
    parameter int E = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         op_i,
    input  logic [E*W-1:0] x_i,
    input  logic [E*W-1:0] y_i,
    input  logic [E*W-1:0] m_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [E*W-1:0] s_o
);

    localparam int IW = $clog2(E + 1);

    logic [W-1:0] x_a [0:E];
    logic [W-1:0] y_a [0:E];
    logic [W-1:0] m_a [0:E];
    logic [W-1:0] t_a [0:E];
    logic [W-1:0] t_q [0:E-1];
    logic [E*W-1:0] s_q;

    logic          fix, sub, first;
    logic [IW-1:0] word_idx;
    logic          ca_q, cb_q, co1, co2, cin1, cin2;
    logic [W-1:0]  a1, b1, r1, b2, r2;

    // Operand words, with a zero sign word above the top
    for (genvar g = 0; g < E; g++) begin : g_words
        assign x_a[g] = x_i[g*W +: W];
        assign y_a[g] = y_i[g*W +: W];
        assign m_a[g] = m_i[g*W +: W];
        assign t_a[g] = t_q[g];
    end
    assign x_a[E] = '0;
    assign y_a[E] = '0;
    assign m_a[E] = '0;
    assign t_a[E] = '0;

    wsmas_ctrl #(.E(E), .IW(IW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .op_i       (op_i),
        .need_fix_i (r2[W-1]),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .fix_o      (fix),
        .sub_o      (sub),
        .first_o    (first),
        .idx_o      (word_idx)
    );

    // Row one: operand sum or difference, pass-through of T when fixing
    assign a1   = fix ? t_a[word_idx] : x_a[word_idx];
    assign b1   = fix ? '0 : (sub ? ~y_a[word_idx] : y_a[word_idx]);
    assign cin1 = first ? (!fix && sub) : ca_q;

    // Row two: modulus term (minus m in an add sum pass, plus m in a sub fix pass)
    assign b2   = fix ? (sub ? m_a[word_idx] : '0)
                      : (sub ? '0 : ~m_a[word_idx]);
    assign cin2 = first ? (!fix && !sub) : cb_q;

    wsmas_word_adder #(.W(W)) u_row1 (
        .a_i(a1), .b_i(b1), .cin_i(cin1), .sum_o(r1), .cout_o(co1)
    );

    wsmas_word_adder #(.W(W)) u_row2 (
        .a_i(r1), .b_i(b2), .cin_i(cin2), .sum_o(r2), .cout_o(co2)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ca_q <= 1'b0;
            cb_q <= 1'b0;
            s_q  <= '0;
            for (int k = 0; k < E; k++) t_q[k] <= '0;
        end else if (busy_o) begin
            ca_q <= co1;
            cb_q <= co2;
            for (int k = 0; k < E; k++) begin
                if (word_idx == IW'(k)) begin
                    if (!fix) t_q[k] <= r1;
                    s_q[k*W +: W] <= r2;
                end
            end
        end
    end

    assign s_o = s_q;

endmodule

// File: rtl/wsmas_checker.sv
module wsmas_checker #(
    parameter int W = 8,
    parameter int E = 4,
    parameter int IW = $clog2(E + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [E*W-1:0] s,
    input logic [IW-1:0]  idx
);

    int run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else run_len <= 0;
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    assert_start_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);

    assert_busy_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= 2 * (E + 1));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(s));

    assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= IW'(E));

endmodule

bind wsmas_top wsmas_checker #(.W(W), .E(E)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_i),
    .busy  (busy_o),
    .done  (done_o),
    .s     (s_o),
    .idx   (word_idx)
);

// File: tb/test_wsmas_top.sv
module test_wsmas_top;

    localparam int W = 4;
    localparam int E = 2;
    localparam int N = W * E;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         op = 1'b0;
    logic [N-1:0] x = '0;
    logic [N-1:0] y = '0;
    logic [N-1:0] m = N'(1);
    logic         busy, done;
    logic [N-1:0] s;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    wsmas_top #(.W(W), .E(E)) i_wsmas_top (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
        .x_i(x), .y_i(y), .m_i(m),
        .busy_o(busy), .done_o(done), .s_o(s)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_op(input int xv, input int yv, input int mv,
                          input bit sub, input bit poke, input string rq);
        int n;
        int expv;
        int passes;
        logic [N-1:0] held;
        @(negedge clk);
        x = N'(xv); y = N'(yv); m = N'(mv); op = sub; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 64) begin
            if (poke && n == 2) begin start = 1'b1; op = !sub; end
            else if (poke && n == 3) begin start = 1'b0; op = sub; end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        if (sub) begin
            expv   = (xv + mv - yv) % mv;
            passes = (xv < yv) ? 2 : 1;
        end else begin
            expv   = (xv + yv) % mv;
            passes = (xv + yv < mv) ? 2 : 1;
        end
        chk(int'(s) == expv, poke ? "R7" : rq, "result", s, expv);
        chk(n == passes * (E + 1) + 1, poke ? "R7" : (sub ? "R4" : "R5"),
            "latency", n, passes * (E + 1) + 1);
        chk(!busy, "R6", "busy with done", busy, 0);
        @(negedge clk);
        chk(!done && !busy, "R6", "done pulse width", done, 0);
        // R8: change operands while idle, result must hold
        held = s;
        x = ~x; y = ~y; m = ~m;
        @(negedge clk);
        @(negedge clk);
        chk(s == held, "R8", "idle hold", s, held);
    endtask

    initial begin
        int ms [7] = '{1, 2, 11, 40, 97, 200, 255};
        #1;
        @(negedge clk);
        chk(!busy && !done && s == '0, "R1", "reset outputs", {busy, done, s}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && s == '0, "R1", "after reset", {busy, done, s}, 0);

        foreach (ms[i]) begin
            int mv;
            int st;
            mv = ms[i];
            st = (mv > 40) ? (mv / 12 + 1) : 1;
            for (int xv = 0; xv < mv; xv += st) begin
                for (int yv = 0; yv < mv; yv += st) begin
                    run_op(xv, yv, mv, 1'b1, (mv == 97) && ((xv + yv) % 7 == 0), "R2");
                    run_op(xv, yv, mv, 1'b0, (mv == 97) && ((xv + yv) % 5 == 0), "R3");
                end
            end
            // R9 boundary cases
            run_op(mv - 1, mv - 1, mv, 1'b1, 1'b0, "R9");
            run_op(mv - 1, 0, mv, 1'b1, 1'b0, "R9");
            run_op(0, mv - 1, mv, 1'b1, 1'b0, "R9");
            if (mv > 1) run_op(mv - 1, 1, mv, 1'b0, 1'b0, "R9");
            run_op(mv - 1, mv - 1, mv, 1'b0, 1'b0, "R9");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R4 watchdog actual=%0d expected=%0d", 190000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule